// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire clock/data bus that holds a small bank of configuration bytes for the surrounding logic. It supports four kinds of access. An indexed byte write and an indexed byte read reach one byte picked by the command code. A block write and a block read always start at offset 0 and walk upward through the bank. A block read first reports how many bytes the bank holds. The bus lines are sampled by the fast system clock through a synchronizer. The slave pulls the data line low through an open-drain enable and never drives it high.

The configuration bytes go to the rest of the chip on one flat vector, with byte n at bits [8n+7:8n]. Each bit has a reset value and can be marked read-only. One byte is a fixed identifier. The low bits of another byte are not stored at all: they read back the live value of a hardware strap input.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset the data line is released and the bank, bytes 0 to 10, holds FE, FE, FF, 00, 07, 00, 18, 01, 44, 0E, 00 (hex).
- R2: The slave acknowledges the address byte D2 (write) and D3 (read), which is 7-bit address 69h. Any other address is not acknowledged, and the slave then leaves the data line released until the next start.
- R3: A command code with bit 7 = 1 selects one byte at offset [6:0]. A command code with bit 7 = 0 selects block access from offset 0.
- R4: An indexed byte write stores the data byte at the addressed offset. An indexed byte read, after a repeated start and address D3, returns that byte most significant bit first. Stored bytes change only on a falling edge of the bus clock.
- R5: A block write acknowledges and discards the count byte, then stores data at offsets 0, 1, 2 and upward. A stop after any complete byte leaves the later offsets unchanged.
- R6: A block read returns the count 0Bh first, then bytes from offset 0 in ascending order, while the master acknowledges. After the master's not-acknowledge the slave releases the data line.
- R7: Read-only bits ignore writes. These are all of byte 7 (identifier 01h), byte 0 bit 0, byte 2 bits [3:1] and byte 6 bits [2:0]. Byte 6 bits [2:0] always read the current hw_strap_i.
- R8: Writes to offsets 11 and above are acknowledged and have no effect. Reads from those offsets return 00h.
- R9: A stop condition returns the slave to idle with the data line released. The slave changes the data line only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| hw_strap_i | input | 3 | Hardware bits shown in byte 6 bits [2:0] |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| cfg_o | output | 88 | Configuration bank, byte n at [8n+7:8n] |

## Verification
A wrong address pointer or a lost count byte in a block access shows up as a shifted byte. It appears on the very next byte read back over the bus, or in cfg_o one system clock after the clock falls to end the data byte. A phase machine that is out of step with the bus shows up as an acknowledge missing or out of place. That is seen on the ninth clock of the byte where it goes wrong, or later as the slave driving the data line while the bus clock is high. A broken read-only mask shows up in cfg_o straight after the write that should have been blocked.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_e;

  typedef enum logic [1:0] {
    CX_ADDR,
    CX_CMD,
    CX_CNT,
    CX_DATA
  } ctx_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_c, sda_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_STAGES-1];
      sda_q  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_c      = scl_ff[SYNC_STAGES-1];
  assign sda_c      = sda_ff[SYNC_STAGES-1];
  assign sda_o      = sda_c;
  assign scl_rise_o = scl_c & ~scl_q;
  assign scl_fall_o = ~scl_c & scl_q;
  // data edges while the clock stays high
  assign start_o    = scl_c & scl_q & sda_q & ~sda_c;
  assign stop_o     = scl_c & scl_q & ~sda_q & sda_c;
endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file #(
  parameter int                    NUM_REGS = 11,
  parameter int                    AW       = 7,
  parameter logic [NUM_REGS*8-1:0] RST_VAL  = '0,
  parameter logic [NUM_REGS*8-1:0] RO_MASK  = '0,
  parameter int                    HW_BYTE  = 6,
  parameter int                    HW_W     = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [HW_W-1:0]       hw_i,
  output logic [7:0]            rd_data_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RV = RST_VAL[g*8+:8];
    localparam logic [7:0] RO = RO_MASK[g*8+:8];
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RV;
      else if (wr_en_i && addr_i == AW'(g)) q <= (wr_data_i & ~RO) | (q & RO);
    end
    assign regs_o[g*8+:8] = q;
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_i == AW'(i)) rd_data_o = regs_o[i*8+:8];
    end
    if (addr_i == AW'(HW_BYTE)) rd_data_o[HW_W-1:0] = hw_i;
  end
endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
  import smb_pkg::*;
#(
  parameter int         NUM_REGS = 11,
  parameter int         AW       = 7,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] ptr_o,
  output logic [7:0]    wr_data_o,
  output logic          sda_oe_o
);
  localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);

  phase_e     phase;
  ctx_e       ctx;
  logic [7:0] shreg;
  logic [3:0] bitcnt;
  logic       rw, blk, cnt_pend, nack;
  logic [AW-1:0] ptr;
  logic       byte_done, load_cnt;
  logic [7:0] tx_byte;

  assign byte_done = scl_fall_i && bitcnt == 4'd8;
  assign load_cnt  = blk & cnt_pend;
  assign tx_byte   = load_cnt ? CNT_BYTE : rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase <= PH_IDLE; ctx <= CX_ADDR; shreg <= '0; bitcnt <= '0;
      rw <= 1'b0; blk <= 1'b0; cnt_pend <= 1'b0; nack <= 1'b0; ptr <= '0;
    end else if (start_i) begin
      phase <= PH_RX; ctx <= CX_ADDR; bitcnt <= '0;
    end else if (stop_i) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_RX: begin
          if (scl_rise_i && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_i};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            bitcnt <= '0;
            phase  <= PH_RX_ACK;
            case (ctx)
              CX_ADDR: begin
                if (shreg[7:1] == DEV_ADDR) rw <= shreg[0];
                else phase <= PH_IDLE;
                ctx <= CX_CMD;
              end
              CX_CMD: begin
                blk      <= ~shreg[7];
                cnt_pend <= ~shreg[7];
                ptr      <= shreg[7] ? shreg[AW-1:0] : '0;
                ctx      <= shreg[7] ? CX_DATA : CX_CNT;
              end
              CX_CNT:  ctx <= CX_DATA;
              default: ptr <= ptr + 1'b1;
            endcase
          end
        end
        PH_RX_ACK: begin
          if (scl_fall_i) begin
            if (rw) begin
              phase  <= PH_TX;
              bitcnt <= '0;
              shreg  <= tx_byte;
              if (load_cnt) cnt_pend <= 1'b0;
              else ptr <= ptr + 1'b1;
            end else begin
              phase <= PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_fall_i) begin
            shreg <= {shreg[6:0], 1'b0};
            if (bitcnt == 4'd7) begin
              phase  <= PH_TX_ACK;
              bitcnt <= '0;
            end else begin
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        PH_TX_ACK: begin
          if (scl_rise_i) nack <= sda_i;
          else if (scl_fall_i) begin
            if (nack) phase <= PH_IDLE;
            else begin
              phase <= PH_TX;
              shreg <= tx_byte;
              if (load_cnt) cnt_pend <= 1'b0;
              else ptr <= ptr + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_en_o   = phase == PH_RX && ctx == CX_DATA && byte_done;
  assign wr_data_o = shreg;
  assign ptr_o     = ptr;
  assign sda_oe_o  = (phase == PH_RX_ACK) | (phase == PH_TX & ~shreg[7]);
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter int                    NUM_REGS    = 11,
  parameter logic [6:0]            DEV_ADDR    = 7'h69,
  parameter int                    SYNC_STAGES = 2,
  parameter int                    HW_BYTE     = 6,
  parameter int                    HW_W        = 3,
  parameter logic [NUM_REGS*8-1:0] RST_VAL     = 88'h00_0E_44_01_18_00_07_00_FF_FE_FE,
  parameter logic [NUM_REGS*8-1:0] RO_MASK     = 88'h00_00_00_FF_07_00_00_00_0E_00_01
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [HW_W-1:0]       hw_strap_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int AW = 7;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [AW-1:0] ptr;
  logic [7:0] wr_data, rd_data;

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_slave_fsm #(.NUM_REGS(NUM_REGS), .AW(AW), .DEV_ADDR(DEV_ADDR)) i_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .ptr_o(ptr), .wr_data_o(wr_data), .sda_oe_o
  );

  smb_reg_file #(
    .NUM_REGS(NUM_REGS), .AW(AW), .RST_VAL(RST_VAL), .RO_MASK(RO_MASK),
    .HW_BYTE(HW_BYTE), .HW_W(HW_W)
  ) i_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .addr_i(ptr), .wr_data_i(wr_data),
    .hw_i(hw_strap_i), .rd_data_o(rd_data), .regs_o(cfg_o)
  );
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
  parameter int                    NUM_REGS = 11,
  parameter logic [NUM_REGS*8-1:0] RST_VAL  = '0,
  parameter logic [NUM_REGS*8-1:0] RO_MASK  = '0
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_i,
  input logic                  sda_oe_o,
  input logic [NUM_REGS*8-1:0] cfg_o,
  input logic                  scl_fall,
  input logic                  stop_det
);
  // R9
  data_only_when_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

  // R9
  release_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  // R7
  ro_bits_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o & RO_MASK) == (RST_VAL & RO_MASK));

  // R4
  write_on_clk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> $past(scl_fall));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(
  .NUM_REGS(NUM_REGS), .RST_VAL(RST_VAL), .RO_MASK(RO_MASK)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .cfg_o(cfg_o), .scl_fall(scl_fall), .stop_det(stop_det)
);

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;
  localparam int N = 11;
  localparam int T = 20;
  localparam logic [N*8-1:0] RST = 88'h00_0E_44_01_18_00_07_00_FF_FE_FE;
  localparam logic [N*8-1:0] RO  = 88'h00_00_00_FF_07_00_00_00_0E_00_01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  logic [N*8-1:0] cfg;
  wire sda_line = sda_m & ~sda_oe;

  int errs = 0, checks = 0;
  logic [7:0] model [N];

  always #2 clk = ~clk;

  smb_cfg_slave i_smb_cfg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .hw_strap_i(strap), .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  task automatic chk(input string req, input logic [87:0] act, input logic [87:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt();
    repeat (T) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    wt(); sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); sda_m = 1'b0; wt(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wt(); sda_m = 1'b0; wt(); scl_m = 1'b1; wt(); sda_m = 1'b1; wt();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      wt(); sda_m = b[i]; wt(); scl_m = 1'b1; wt(); scl_m = 1'b0;
    end
    wt(); sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); ack = ~sda_line; scl_m = 1'b0;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wt(); sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); b[i] = sda_line; scl_m = 1'b0;
    end
    wt(); sda_m = ~give_ack; wt(); scl_m = 1'b1; wt(); scl_m = 1'b0;
  endtask

  function automatic logic [7:0] rd_exp(input int off);
    if (off >= N) return 8'h00;
    if (off == 6) return {model[6][7:3], strap};
    return model[off];
  endfunction

  function automatic logic [N*8-1:0] model_vec();
    logic [N*8-1:0] v;
    for (int i = 0; i < N; i++) v[i*8+:8] = model[i];
    return v;
  endfunction

  task automatic model_wr(input int off, input logic [7:0] d);
    if (off < N) model[off] = (d & ~RO[off*8+:8]) | (model[off] & RO[off*8+:8]);
  endtask

  task automatic reg_write(input string req, input logic [6:0] off, input logic [7:0] d);
    logic a0, a1, a2;
    bus_start(); wr_byte(8'hD2, a0); wr_byte({1'b1, off}, a1); wr_byte(d, a2); bus_stop();
    chk({req, " ack on byte write"}, {a0, a1, a2}, 3'b111);
    model_wr(int'(off), d);
  endtask

  task automatic reg_read(input logic [6:0] off, output logic [7:0] v);
    logic a0, a1, a2;
    bus_start(); wr_byte(8'hD2, a0); wr_byte({1'b1, off}, a1);
    bus_start(); wr_byte(8'hD3, a2); rd_byte(1'b0, v); bus_stop();
    chk("R2 ack on byte read", {a0, a1, a2}, 3'b111);
  endtask

  task automatic t_reset();
    chk("R1 reset bank", cfg, RST);
    chk("R1 line released", sda_oe, 1'b0);
  endtask

  task automatic t_byte_access();
    logic [7:0] v;
    reg_write("R3", 7'd3, 8'hA5);
    chk("R4 byte write stored", cfg, model_vec());
    reg_read(7'd3, v);
    chk("R4 byte read", v, 8'hA5);
    reg_read(7'd1, v);
    chk("R3 byte read other offset", v, rd_exp(1));
  endtask

  task automatic t_bad_addr();
    logic a0, a1;
    bus_start(); wr_byte(8'hA4, a0); wr_byte(8'h83, a1); bus_stop();
    chk("R2 foreign address nack", a0, 1'b0);
    chk("R2 no ack after foreign address", a1, 1'b0);
    chk("R2 bank unchanged", cfg, model_vec());
  endtask

  task automatic t_block_write();
    logic a0, a1, a2, a3, a4, a5;
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h00, a1); wr_byte(8'h03, a2);
    wr_byte(8'h11, a3); wr_byte(8'h22, a4); wr_byte(8'h33, a5); bus_stop();
    chk("R5 block write acks", {a0, a1, a2, a3, a4, a5}, 6'h3F);
    model_wr(0, 8'h11); model_wr(1, 8'h22); model_wr(2, 8'h33);
    chk("R5 block write bank", cfg, model_vec());
    chk("R5 offset 3 untouched", cfg[31:24], 8'hA5);
  endtask

  task automatic t_block_read();
    logic a0, a1, a2;
    logic [7:0] v;
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h00, a1);
    bus_start(); wr_byte(8'hD3, a2);
    chk("R6 block read acks", {a0, a1, a2}, 3'b111);
    rd_byte(1'b1, v);
    chk("R6 count byte", v, 8'h0B);
    for (int i = 0; i < N; i++) begin
      rd_byte(i != N - 1, v);
      chk($sformatf("R6 block byte %0d", i), v, rd_exp(i));
    end
    wt();
    chk("R6 released after nack", sda_oe, 1'b0);
    bus_stop();
    chk("R9 idle after stop", sda_oe, 1'b0);
  endtask

  task automatic t_read_only();
    logic [7:0] v;
    reg_write("R7", 7'd7, 8'h00);
    reg_read(7'd7, v);
    chk("R7 identifier fixed", v, 8'h01);
    reg_write("R7", 7'd6, 8'hE0);
    reg_read(7'd6, v);
    chk("R7 strap bits 101", v, 8'hE5);
    strap = 3'b010;
    reg_read(7'd6, v);
    chk("R7 strap bits 010", v, 8'hE2);
    chk("R7 bank", cfg, model_vec());
  endtask

  task automatic t_range();
    logic [7:0] v;
    reg_write("R8", 7'h20, 8'h5A);
    chk("R8 bank unchanged", cfg, model_vec());
    reg_read(7'h20, v);
    chk("R8 read beyond bank", v, 8'h00);
  endtask

  task automatic t_stop_mid();
    logic a0, a1;
    logic [7:0] v;
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h84, a1); bus_stop();
    chk("R9 stop before data keeps bank", cfg, model_vec());
    reg_write("R9", 7'd4, 8'h3C);
    reg_read(7'd4, v);
    chk("R9 access after early stop", v, 8'h3C);
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = RST[i*8+:8];
    repeat (5) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    wt();
    t_reset();
    t_byte_access();
    t_bad_addr();
    t_block_write();
    t_block_read();
    t_read_only();
    t_range();
    t_stop_mid();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule